// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

A free-running 64-bit fixed-point system time. Each oscillator cycle adds a programmable step to the count, so the low-order bits hold a binary fraction of a nanosecond. The integer nanosecond count is the stored value shifted right by an amount set by the line-rate selector. Software adjusts frequency by rewriting the step register. The new step applies from the next cycle and the running count is never reloaded. One build parameter picks between two step formats. The wide format has a 31-bit step. The narrow format has a 24-bit step plus an 8-bit cycle-period field that spaces the additions.

Software reaches the counter through a plain register port. Three addresses are used: time low half, time high half and step configuration. A read of the low half also copies the high half into a shadow register, so a later read of the high half matches that instant. A write to the low half is held in a staging register. The following write to the high half loads both halves into the counter in one cycle. The port has no back-pressure: every request is accepted in the cycle it is presented, and read data comes back exactly one cycle later with a one-cycle valid pulse.

Top module: `tod_counter`

## Requirements
- R1: In the wide format the count grows by bits [30:0] of the step register on every clock; bit 31 of that register has no effect on the count.
- R2: In the narrow format the step is bits [23:0] and the period P is bits [31:23+1]. The count grows by the step once every P cycles, and P = 0 halts it. The period phase restarts on a time load or a step-register write, so the first addition comes P cycles after that event.
- R3: The count wraps modulo 2^64 with no saturation.
- R4: `time_ns` equals the count shifted right by 28 (speed_sel 0 or 3), 24 (speed_sel 1) or 21 (speed_sel 2). The narrow format uses each of these shifts minus 7.
- R5: `base_step` gives the nominal step for the selected speed: 0x66666666 (speed_sel 0 or 3), 0x40000000 (speed_sel 1) or 0x50000000 (speed_sel 2). The narrow format gives these values shifted right by 7.
- R6: A write to address 0 only fills the staging register and leaves the count unchanged. A write to address 1 loads {wdata, staging} into the count at that clock edge.
- R7: A read of address 0 returns the low 32 bits of the count as they stood in the request cycle, and copies the high 32 bits of that same cycle into the shadow. A read of address 1 returns the shadow.
- R8: A write to address 2 replaces the step configuration. The count still advances by the old step in the write cycle and by the new step from the following cycle.
- R9: `rd_valid` pulses high for one cycle, exactly one cycle after each read request, and `rd_data` is valid with it. Address 2 reads back the step configuration. Address 3 reads as zero, and writes to it are ignored.
- R10: After reset the count, staging, shadow and step configuration are all zero, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Line-rate selector for nanosecond shift and nominal step |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 time low, 1 time high, 2 step config, 3 spare |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | 32 | Read data |
| time_ns | output | 64 | Count shifted down to whole nanoseconds |
| base_step | output | 32 | Nominal step for the selected speed |

## Verification
A table of step values, start counts and idle spans drives the accumulation path. It covers a typical fractional step, a step that carries into the high half, a load just below 2^64 that must wrap, a step with bit 31 set that the wide format must ignore, and a zero step that must freeze the count. A second instance built in the narrow format gets the same bus traffic, with periods of 1, 2 and 3 cycles, so its additions must fall on exact multiples of the period. Directed cases then separate staging from loading, shadow coherence from a live high-half read, and an old-step cycle from a new-step cycle around a step rewrite. They also check every speed code against both shift tables.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_W      = 32;
  localparam int TIME_W     = 64;
  localparam int NAR_INC_W  = 24;
  localparam int NAR_DROP   = 7;

  typedef enum logic [1:0] {
    RA_TIME_LO  = 2'd0,
    RA_TIME_HI  = 2'd1,
    RA_STEP_CFG = 2'd2,
    RA_SPARE    = 2'd3
  } reg_addr_e;

  function automatic logic [5:0] ns_shift(input logic [1:0] spd, input logic narrow);
    logic [5:0] s;
    case (spd)
      2'd1:    s = 6'd24;
      2'd2:    s = 6'd21;
      default: s = 6'd28;
    endcase
    if (narrow) s = s - 6'(NAR_DROP);
    return s;
  endfunction

  function automatic logic [REG_W-1:0] nominal_step(input logic [1:0] spd, input logic narrow);
    logic [REG_W-1:0] v;
    case (spd)
      2'd1:    v = 32'h4000_0000;
      2'd2:    v = 32'h5000_0000;
      default: v = 32'h6666_6666;
    endcase
    if (narrow) v = v >> NAR_DROP;
    return v;
  endfunction
endpackage

// File: rtl/tod_step_unit.sv
module tod_step_unit #(
  parameter int INC_W = 31,
  parameter int PER_W = 1,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [INC_W-1:0] inc,
  input  logic [PER_W-1:0] period,
  output logic [OUT_W-1:0] step,
  output logic             adv
);
  logic [PER_W-1:0] phase_q;

  assign adv  = (period != '0) && (phase_q == period - 1'b1);
  assign step = OUT_W'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (restart)        phase_q <= '0;
    else if (period != '0)   phase_q <= adv ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              adv,
  input  logic [TIME_W-1:0] step,
  output logic [TIME_W-1:0] time_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     time_q <= '0;
    else if (load)  time_q <= load_val;
    else if (adv)   time_q <= time_q + step;
  end
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int TW = 64,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic [TW-1:0] time_q,
  output logic [RW-1:0] cfg_q,
  output logic [RW-1:0] stage_q,
  output logic [RW-1:0] shadow_q,
  output logic          load,
  output logic [TW-1:0] load_val,
  output logic          cfg_wr,
  output logic          rd_valid,
  output logic [RW-1:0] rd_data
);
  reg_addr_e addr;
  assign addr     = reg_addr_e'(reg_addr);
  assign load     = reg_wr && (addr == RA_TIME_HI);
  assign cfg_wr   = reg_wr && (addr == RA_STEP_CFG);
  assign load_val = {reg_wdata, stage_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cfg_q   <= '0;
    end else if (reg_wr) begin
      if (addr == RA_TIME_LO)  stage_q <= reg_wdata;
      if (addr == RA_STEP_CFG) cfg_q   <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      shadow_q <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) begin
        case (addr)
          RA_TIME_LO: begin
            rd_data  <= time_q[RW-1:0];
            shadow_q <= time_q[TW-1:RW];
          end
          RA_TIME_HI:  rd_data <= shadow_q;
          RA_STEP_CFG: rd_data <= cfg_q;
          default:     rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int TW     = TIME_W,
  parameter int RW     = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic          rd_valid,
  output logic [RW-1:0] rd_data,
  output logic [TW-1:0] time_ns,
  output logic [RW-1:0] base_step
);
  localparam int WIDE_INC_W = RW - 1;
  localparam int NAR_PER_W  = RW - NAR_INC_W;

  logic [TW-1:0] time_q;
  logic [TW-1:0] load_val;
  logic [TW-1:0] step_w;
  logic [RW-1:0] cfg_q, stage_q, shadow_q;
  logic          load_w, cfg_wr_w, adv_w, restart_w;

  assign restart_w = load_w | cfg_wr_w;

  tod_regif #(.TW(TW), .RW(RW)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .time_q(time_q), .cfg_q(cfg_q), .stage_q(stage_q), .shadow_q(shadow_q),
    .load(load_w), .load_val(load_val), .cfg_wr(cfg_wr_w),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  generate
    if (NARROW) begin : g_narrow
      tod_step_unit #(.INC_W(NAR_INC_W), .PER_W(NAR_PER_W), .OUT_W(TW)) u_step (
        .clk(clk), .rst_n(rst_n), .restart(restart_w),
        .inc(cfg_q[NAR_INC_W-1:0]), .period(cfg_q[RW-1:NAR_INC_W]),
        .step(step_w), .adv(adv_w)
      );
    end else begin : g_wide
      tod_step_unit #(.INC_W(WIDE_INC_W), .PER_W(1), .OUT_W(TW)) u_step (
        .clk(clk), .rst_n(rst_n), .restart(restart_w),
        .inc(cfg_q[WIDE_INC_W-1:0]), .period(1'b1),
        .step(step_w), .adv(adv_w)
      );
    end
  endgenerate

  tod_accum #(.TIME_W(TW)) u_accum (
    .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(load_val),
    .adv(adv_w), .step(step_w), .time_q(time_q)
  );

  assign time_ns   = time_q >> ns_shift(speed_sel, NARROW);
  assign base_step = nominal_step(speed_sel, NARROW);
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int TW = 64,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [RW-1:0] reg_wdata,
  input logic          rd_valid,
  input logic [RW-1:0] rd_data,
  input logic [TW-1:0] time_q,
  input logic [RW-1:0] stage_q,
  input logic [RW-1:0] shadow_q,
  input logic [TW-1:0] step_w,
  input logic          adv_w
);
  // R1/R3: without a load the count moves only by the step unit's output, modulo 2^64
  assert_accum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == 2'd1) |->
      time_q == $past(time_q) + ($past(adv_w) ? $past(step_w) : '0));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 2'd1) |-> time_q == {$past(reg_wdata), $past(stage_q)});

  assert_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 2'd0) |-> stage_q == $past(reg_wdata));

  assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && reg_addr == 2'd0) |-> shadow_q == $past(time_q[TW-1:RW]));

  assert_hiread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && reg_addr == 2'd1) |-> rd_data == $past(shadow_q));

  assert_rdvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(reg_rd));
endmodule

bind tod_counter tod_counter_chk #(.TW(TW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .time_q(time_q),
  .stage_q(stage_q), .shadow_q(shadow_q), .step_w(step_w), .adv_w(adv_w)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  speed_sel = 2'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        rd_valid, rd_valid_n;
  logic [31:0] rd_data, rd_data_n, base_step, base_step_n;
  logic [63:0] time_ns, time_ns_n;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tod_counter #(.NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .time_ns(time_ns), .base_step(base_step));

  tod_counter #(.NARROW(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid_n), .rd_data(rd_data_n),
    .time_ns(time_ns_n), .base_step(base_step_n));

  localparam int NV = 6;
  localparam logic [31:0] VCFG  [NV] = '{32'h6666_6666, 32'h6666_6666, 32'h4000_0000,
                                         32'h7FFF_FFFF, 32'hE666_6666, 32'h0000_0000};
  localparam logic [63:0] VLOAD [NV] = '{64'h0, 64'h0, 64'h0000_0001_0000_0000,
                                         64'hFFFF_FFFF_FFFF_FFF0, 64'h5, 64'h1234_5678_9ABC_DEF0};
  localparam int          VIDLE [NV] = '{0, 10, 7, 1, 3, 20};

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one clock edge with the given request; returns at the following negedge with inputs idle
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic load(input logic [63:0] v);
    cyc(1'b1, 1'b0, 2'd0, v[31:0]);
    cyc(1'b1, 1'b0, 2'd1, v[63:32]);
  endtask

  task automatic snap(output logic [63:0] vw, output logic [63:0] vn);
    cyc(1'b0, 1'b1, 2'd0, 32'h0);
    vw[31:0] = rd_data; vn[31:0] = rd_data_n;
    cyc(1'b0, 1'b1, 2'd1, 32'h0);
    vw[63:32] = rd_data; vn[63:32] = rd_data_n;
  endtask

  function automatic int shift_of(input logic [1:0] s, input bit narrow);
    int v;
    v = (s == 2'd1) ? 24 : (s == 2'd2) ? 21 : 28;
    return narrow ? v - 7 : v;
  endfunction

  function automatic logic [31:0] nom_of(input logic [1:0] s, input bit narrow);
    logic [31:0] v;
    v = (s == 2'd1) ? 32'h4000_0000 : (s == 2'd2) ? 32'h5000_0000 : 32'h6666_6666;
    return narrow ? (v >> 7) : v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] vw, vn, exp;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 rd_valid", {63'h0, rd_valid}, 64'h0);
    chk("R10 time_ns", time_ns, 64'h0);
    snap(vw, vn);
    chk("R10 count", vw, 64'h0);
    cyc(1'b0, 1'b1, 2'd2, 32'h0);
    chk("R10 cfg", {32'h0, rd_data}, 64'h0);

    // R1 R3 vector table (wide instance)
    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, 1'b0, 2'd2, VCFG[i]);
      load(VLOAD[i]);
      idle(VIDLE[i]);
      snap(vw, vn);
      exp = VLOAD[i] + 64'(VIDLE[i]) * {33'h0, VCFG[i][30:0]};
      chk(i == 3 ? "R3 wrap" : "R1 accumulate", vw, exp);
    end

    // R9: valid pulse and readback
    cyc(1'b0, 1'b1, 2'd2, 32'h0);
    chk("R9 valid", {63'h0, rd_valid}, 64'h1);
    chk("R9 cfg readback", {32'h0, rd_data}, 64'h0);
    idle(1);
    chk("R9 valid drops", {63'h0, rd_valid}, 64'h0);
    cyc(1'b1, 1'b0, 2'd3, 32'hDEAD_BEEF);
    cyc(1'b0, 1'b1, 2'd3, 32'h0);
    chk("R9 spare reads zero", {32'h0, rd_data}, 64'h0);
    snap(vw, vn);
    chk("R9 spare write ignored", vw, 64'h1234_5678_9ABC_DEF0);

    // R6: staging alone leaves count, high write commits
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_AAAA);
    idle(2);
    snap(vw, vn);
    chk("R6 staged no effect", vw, 64'h1234_5678_9ABC_DEF0);
    cyc(1'b1, 1'b0, 2'd0, 32'h0000_AAAA);
    idle(1);
    cyc(1'b1, 1'b0, 2'd1, 32'h0000_0055);
    snap(vw, vn);
    chk("R6 atomic load", vw, 64'h0000_0055_0000_AAAA);

    // R4 R5: shift and nominal step per speed, both formats (count frozen)
    for (int s = 0; s < 4; s++) begin
      speed_sel = 2'(s);
      @(negedge clk);
      chk("R4 wide shift", time_ns, 64'h0000_0055_0000_AAAA >> shift_of(2'(s), 1'b0));
      chk("R4 narrow shift", time_ns_n, 64'h0000_0055_0000_AAAA >> shift_of(2'(s), 1'b1));
      chk("R5 wide nominal", {32'h0, base_step}, {32'h0, nom_of(2'(s), 1'b0)});
      chk("R5 narrow nominal", {32'h0, base_step_n}, {32'h0, nom_of(2'(s), 1'b1)});
    end
    speed_sel = 2'd0;

    // R7: shadow coherence
    cyc(1'b1, 1'b0, 2'd2, 32'h7FFF_FFFF);
    load(64'h0000_0000_F000_0000);
    cyc(1'b0, 1'b1, 2'd0, 32'h0);
    chk("R7 low read", {32'h0, rd_data}, 64'hF000_0000);
    idle(5);
    cyc(1'b0, 1'b1, 2'd1, 32'h0);
    chk("R7 high from shadow", {32'h0, rd_data}, 64'h0);
    cyc(1'b0, 1'b1, 2'd1, 32'h0);
    chk("R7 shadow held", {32'h0, rd_data}, 64'h0);

    // R8: step rewrite does not disturb count
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_1000);
    load(64'h0);
    cyc(1'b1, 1'b0, 2'd2, 32'h0000_0010);
    idle(3);
    snap(vw, vn);
    chk("R8 old then new step", vw, 64'h1030);

    // R2: narrow period spacing
    for (int p = 1; p <= 3; p++) begin
      cyc(1'b1, 1'b0, 2'd2, {8'(p), 24'h000100});
      load(64'h0);
      idle(7);
      snap(vw, vn);
      chk("R2 narrow period", vn, 64'((7 / p) * 32'h100));
    end
    cyc(1'b1, 1'b0, 2'd2, 32'h00FF_FFFF);
    load(64'h77);
    idle(6);
    snap(vw, vn);
    chk("R2 period zero halts", vn, 64'h77);

    finish_run();
  end
endmodule